// File: doc/BRIEF.md
# Byte-Stream Instruction Sequencer

This block is a small 8-bit processing core. It fetches instructions one byte at a time from an external 256-byte synchronous memory and executes each instruction before it fetches the next. An instruction is an opcode byte followed by one to three operand bytes. The core sequences a different number of operand fetches for each opcode. Operands that name memory cost two more cycles each: one to present the address and one to capture the returned byte. The core keeps six 8-bit general registers (selectors 0x00..0x05, referred to as A, B, C, X, Y, Z) and an 8-bit program counter.

The memory port is a plain fixed-latency port, not a stream. Every address the core drives is sampled on the next rising edge, and the addressed byte appears on `mem_rdata` after that edge. The port has no handshake and no back-pressure, so the memory must answer every read in exactly one cycle. A cycle with `mem_we` high writes `mem_wdata` to `mem_addr`. In that cycle the memory leaves its read data unchanged.

Top module: `seq8_core`

## Requirements
- R1: While `rst_n` is low (asynchronous, active-low) the core drives `mem_addr`=0x00 and `mem_we`=0. After release its first fetch is from address 0x00. All six registers start at 0x00.
- R2: Opcode 0x01 (3 bytes: opcode, register selector, value) loads the value into the selected register.
- R3: Opcode 0x03 (3 bytes: opcode, dest selector, source selector) sets dest to dest + source modulo 256.
- R4: Opcodes 0x04 (reg += mem[a]), 0x05 (mem[a] += reg) and 0x06 (mem[a] += mem[b]) are 3 bytes each. They treat a memory operand byte as an address and read it in an extra cycle pair. A memory destination receives the sum through a single write cycle to the address in the first operand byte.
- R5: Opcode 0x02 (3 bytes: opcode, dest selector, address) loads the memory byte at that address into the register.
- R6: Opcode 0x07 (4 bytes: opcode, selector, selector, target) loads the PC with the target when the two registers are equal. Otherwise execution continues at the next instruction.
- R7: Opcodes 0x08 (register vs memory byte) and 0x09 (memory byte vs memory byte) branch in the same way. Their operands are ordered the same way.
- R8: Opcode 0x0A (2 bytes) loads the PC from the selected register. Opcode 0x0B (2 bytes) loads it from the memory byte at the operand address.
- R9: Opcode 0x00 and every opcode from 0x0C to 0xFF execute as one-byte no-ops that take two cycles.
- R10: A selector byte above 0x05 reads as 0x00. A write through such a selector changes no register.
- R11: The PC steps from 0xFF to 0x00, and an instruction may straddle that boundary.
- R12: An instruction with n operand bytes and m memory operands takes 3 + n + 2m cycles. Any write occurs in its last cycle.
- R13: `mem_we` is never high for two consecutive cycles, and only a memory-destination add raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Byte address presented to memory |
| mem_we | output | 1 | Write strobe, one cycle per memory-destination add |
| mem_wdata | output | 8 | Byte written when `mem_we` is high |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |

## Verification
A corrupted PC or sequencing state shows up within one instruction. The next `mem_addr` values drift from the expected byte stream, and the next write lands at the wrong cycle or address. A wrong register value is hidden until an instruction consumes it. The bench therefore copies registers into cleared memory bytes with memory-destination adds, which turns register state into a write that is visible at the ports and has a known cycle number. A wrong operand count or memory-read count moves the first write by whole cycles. The bench catches that by comparing the write cycle against the 3 + n + 2m rule over a long nested loop.

// File: rtl/seq8_pkg.sv
package seq8_pkg;

  localparam logic [7:0] OPC_NOP    = 8'h00;
  localparam logic [7:0] OPC_LDI    = 8'h01;
  localparam logic [7:0] OPC_LDM    = 8'h02;
  localparam logic [7:0] OPC_ADD_RR = 8'h03;
  localparam logic [7:0] OPC_ADD_RM = 8'h04;
  localparam logic [7:0] OPC_ADD_MR = 8'h05;
  localparam logic [7:0] OPC_ADD_MM = 8'h06;
  localparam logic [7:0] OPC_BEQ_RR = 8'h07;
  localparam logic [7:0] OPC_BEQ_RM = 8'h08;
  localparam logic [7:0] OPC_BEQ_MM = 8'h09;
  localparam logic [7:0] OPC_JMP_R  = 8'h0A;
  localparam logic [7:0] OPC_JMP_M  = 8'h0B;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DEC, ST_OP1, ST_OP2, ST_OP3,
    ST_RDA, ST_RDA_W, ST_RDB, ST_RDB_W, ST_EXEC
  } state_t;

  // Decoded control word for one opcode.
  typedef struct packed {
    logic       valid;   // defined, non-empty instruction
    logic [1:0] nops;    // operand bytes after the opcode
    logic       mem_a;   // first operand is a memory address
    logic       mem_b;   // second operand is a memory address
    logic       imm_b;   // second operand is an immediate
    logic       is_add;
    logic       dst_mem; // sum goes back to memory
    logic       wr_reg;  // result goes to a register
    logic       is_br;
    logic       is_jmp;
  } dec_t;

  function automatic dec_t decode_op(input logic [7:0] op);
    dec_t d;
    d = '0;
    d.valid = 1'b1;
    unique case (op)
      OPC_LDI:    begin d.nops = 2'd2; d.imm_b = 1'b1; d.wr_reg = 1'b1; end
      OPC_LDM:    begin d.nops = 2'd2; d.mem_b = 1'b1; d.wr_reg = 1'b1; end
      OPC_ADD_RR: begin d.nops = 2'd2; d.is_add = 1'b1; d.wr_reg = 1'b1; end
      OPC_ADD_RM: begin d.nops = 2'd2; d.is_add = 1'b1; d.wr_reg = 1'b1; d.mem_b = 1'b1; end
      OPC_ADD_MR: begin d.nops = 2'd2; d.is_add = 1'b1; d.dst_mem = 1'b1; d.mem_a = 1'b1; end
      OPC_ADD_MM: begin d.nops = 2'd2; d.is_add = 1'b1; d.dst_mem = 1'b1; d.mem_a = 1'b1;
                        d.mem_b = 1'b1; end
      OPC_BEQ_RR: begin d.nops = 2'd3; d.is_br = 1'b1; end
      OPC_BEQ_RM: begin d.nops = 2'd3; d.is_br = 1'b1; d.mem_b = 1'b1; end
      OPC_BEQ_MM: begin d.nops = 2'd3; d.is_br = 1'b1; d.mem_a = 1'b1; d.mem_b = 1'b1; end
      OPC_JMP_R:  begin d.nops = 2'd1; d.is_jmp = 1'b1; end
      OPC_JMP_M:  begin d.nops = 2'd1; d.is_jmp = 1'b1; d.mem_a = 1'b1; end
      default:    d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/seq8_regfile.sv
module seq8_regfile #(
  parameter int W    = 8,
  parameter int NREG = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sel_a,
  input  logic [W-1:0] sel_b,
  output logic [W-1:0] rd_a,
  output logic [W-1:0] rd_b,
  input  logic         we,
  input  logic [W-1:0] wsel,
  input  logic [W-1:0] wdata
);
  localparam int FLAT_W = NREG * W;

  logic [FLAT_W-1:0] flat;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       q <= '0;
      else if (we && wsel == W'(g))     q <= wdata;
    end
    assign flat[g*W +: W] = q;
  end

  // Out-of-range selectors match no register and read as zero.
  always_comb begin
    rd_a = '0;
    rd_b = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel_a == W'(i)) rd_a = flat[i*W +: W];
      if (sel_b == W'(i)) rd_b = flat[i*W +: W];
    end
  end

  // R10: a write through an unused selector leaves every register unchanged
  a_r10_bad_sel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wsel >= W'(NREG)) |=> $stable(flat));

endmodule

// File: rtl/seq8_alu.sv
module seq8_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         eq
);
  // Carry out is dropped: results wrap modulo 2**W.
  assign sum = a + b;
  assign eq  = (a == b);
endmodule

// File: rtl/seq8_ctrl.sv
module seq8_ctrl
  import seq8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] mem_addr,
  output logic         mem_we,
  output logic [W-1:0] mem_wdata,
  output logic [W-1:0] sel_a,
  output logic [W-1:0] sel_b,
  input  logic [W-1:0] reg_a,
  input  logic [W-1:0] reg_b,
  output logic         reg_we,
  output logic [W-1:0] reg_wsel,
  output logic [W-1:0] reg_wdata,
  output logic [W-1:0] alu_a,
  output logic [W-1:0] alu_b,
  input  logic [W-1:0] alu_sum,
  input  logic         alu_eq
);
  state_t       state, state_nx, after_ops;
  logic [W-1:0] pc, pc_nx;
  logic [W-1:0] op1, op2, op3, ma, mb;
  logic [W-1:0] val_a, val_b;
  dec_t         ir, dec_now;

  assign dec_now = decode_op(mem_rdata[7:0]);
  assign sel_a   = op1;
  assign sel_b   = op2;

  always_comb begin
    val_a = ir.mem_a ? ma : reg_a;
    val_b = ir.imm_b ? op2 : (ir.mem_b ? mb : reg_b);
    alu_a = val_a;
    alu_b = val_b;

    after_ops = ir.mem_a ? ST_RDA : (ir.mem_b ? ST_RDB : ST_EXEC);

    state_nx  = state;
    pc_nx     = pc;
    mem_addr  = pc;
    mem_we    = 1'b0;
    mem_wdata = alu_sum;
    reg_we    = 1'b0;
    reg_wsel  = op1;
    reg_wdata = ir.is_add ? alu_sum : val_b;

    unique case (state)
      ST_FETCH: begin
        pc_nx    = pc + 1'b1;
        state_nx = ST_DEC;
      end
      ST_DEC: begin
        if (dec_now.valid) begin
          pc_nx    = pc + 1'b1;
          state_nx = ST_OP1;
        end else begin
          state_nx = ST_FETCH;
        end
      end
      ST_OP1: begin
        if (ir.nops > 2'd1) begin
          pc_nx    = pc + 1'b1;
          state_nx = ST_OP2;
        end else begin
          state_nx = after_ops;
        end
      end
      ST_OP2: begin
        if (ir.nops > 2'd2) begin
          pc_nx    = pc + 1'b1;
          state_nx = ST_OP3;
        end else begin
          state_nx = after_ops;
        end
      end
      ST_OP3: state_nx = after_ops;
      ST_RDA: begin
        mem_addr = op1;
        state_nx = ST_RDA_W;
      end
      ST_RDA_W: state_nx = ir.mem_b ? ST_RDB : ST_EXEC;
      ST_RDB: begin
        mem_addr = op2;
        state_nx = ST_RDB_W;
      end
      ST_RDB_W: state_nx = ST_EXEC;
      ST_EXEC: begin
        reg_we = ir.wr_reg;
        if (ir.dst_mem) begin
          mem_we   = 1'b1;
          mem_addr = op1;
        end
        if (ir.is_br && alu_eq) pc_nx = op3;
        if (ir.is_jmp)          pc_nx = val_a;
        state_nx = ST_FETCH;
      end
      default: state_nx = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FETCH;
      pc    <= '0;
      ir    <= '0;
      op1   <= '0;
      op2   <= '0;
      op3   <= '0;
      ma    <= '0;
      mb    <= '0;
    end else begin
      state <= state_nx;
      pc    <= pc_nx;
      if (state == ST_DEC)   ir  <= dec_now;
      if (state == ST_OP1)   op1 <= mem_rdata;
      if (state == ST_OP2)   op2 <= mem_rdata;
      if (state == ST_OP3)   op3 <= mem_rdata;
      if (state == ST_RDA_W) ma  <= mem_rdata;
      if (state == ST_RDB_W) mb  <= mem_rdata;
    end
  end

  // R13: a write strobe never lasts into a second cycle
  a_r13_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R4: a memory write only ever follows the capture of a memory operand
  a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(state) == ST_RDA_W || $past(state) == ST_RDB_W));

  // R11: every opcode fetch advances the PC by one, wrapping at the top
  a_r11_fetch_steps_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH) |=> (pc == $past(pc) + 1'b1));

  // R9: an empty or unknown opcode returns straight to fetch
  a_r9_noop_short: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEC && !dec_now.valid) |=> (state == ST_FETCH && $stable(pc)));

  // R6: a taken branch lands on the target byte
  a_r6_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && ir.is_br && alu_eq) |=> (pc == $past(op3)));

endmodule

// File: rtl/seq8_core.sv
module seq8_core #(
  parameter int W    = 8,
  parameter int NREG = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] mem_addr,
  output logic         mem_we,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata
);
  logic [W-1:0] sel_a, sel_b, reg_a, reg_b;
  logic         reg_we;
  logic [W-1:0] reg_wsel, reg_wdata;
  logic [W-1:0] alu_a, alu_b, alu_sum;
  logic         alu_eq;

  seq8_ctrl #(.W(W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .reg_a     (reg_a),
    .reg_b     (reg_b),
    .reg_we    (reg_we),
    .reg_wsel  (reg_wsel),
    .reg_wdata (reg_wdata),
    .alu_a     (alu_a),
    .alu_b     (alu_b),
    .alu_sum   (alu_sum),
    .alu_eq    (alu_eq)
  );

  seq8_regfile #(.W(W), .NREG(NREG)) rf_i (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_a (sel_a),
    .sel_b (sel_b),
    .rd_a  (reg_a),
    .rd_b  (reg_b),
    .we    (reg_we),
    .wsel  (reg_wsel),
    .wdata (reg_wdata)
  );

  seq8_alu #(.W(W)) alu_i (
    .a   (alu_a),
    .b   (alu_b),
    .sum (alu_sum),
    .eq  (alu_eq)
  );

  // R1: held in reset, the core reads address zero and never writes
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (mem_addr == '0 && !mem_we));

endmodule

// File: tb/seq8_core_tb_top.sv
module seq8_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we;

  logic       ld_en = 1'b0, clr = 1'b0;
  logic [7:0] ld_addr = '0, ld_data = '0;
  logic [7:0] mem [256];

  int checks = 0, errors = 0;
  int cyc, wcount, first_cyc, first_addr, first_data;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seq8_core dut_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Memory model: one-cycle read latency, write wins, reset clears read data.
  always @(posedge clk or negedge rst_n)
    if (!rst_n)       mem_rdata <= 8'h00;
    else if (!mem_we) mem_rdata <= mem[mem_addr];

  always @(posedge clk)
    if (clr)                  for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    else if (ld_en)           mem[ld_addr] <= ld_data;
    else if (rst_n && mem_we) mem[mem_addr] <= mem_wdata;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  always @(negedge clk)
    if (!rst_n) begin
      wcount = 0; first_cyc = -1; first_addr = -1; first_data = -1;
    end else if (mem_we) begin
      if (first_cyc < 0) begin
        first_cyc = cyc; first_addr = mem_addr; first_data = mem_wdata;
      end
      wcount++;
    end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [7:0] d);
    ld_addr = a[7:0]; ld_data = d; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic ins(input int a, input int n, input logic [7:0] b0,
                     input logic [7:0] b1, input logic [7:0] b2, input logic [7:0] b3);
    put(a, b0);
    if (n > 1) put(a + 1, b1);
    if (n > 2) put(a + 2, b2);
    if (n > 3) put(a + 3, b3);
  endtask

  task automatic prep();
    rst_n = 1'b0;
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic go(input int n);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    prep();
    #1;
    chk("R1 addr in reset", mem_addr, 8'h00);
    chk("R1 we in reset", mem_we, 0);
    put(8'hF0, 8'h05); put(8'hF1, 8'h07);
    ins(0, 3, 8'h05, 8'hF0, 8'h00, 0);   // mem[F0] += A
    ins(3, 3, 8'h05, 8'hF1, 8'h05, 0);   // mem[F1] += Z
    ins(6, 4, 8'h07, 8'h00, 8'h00, 8'h06);
    rst_n = 1'b1;
    #1;
    chk("R1 first fetch address", mem_addr, 8'h00);
    @(negedge clk);
    chk("R1 second address", mem_addr, 8'h01);
    repeat (30) @(negedge clk);
    chk("R1 A clear", mem[8'hF0], 8'h05);
    chk("R1 Z clear", mem[8'hF1], 8'h07);
  endtask

  task automatic t_ldi();
    prep();
    ins(0, 3, 8'h01, 8'h00, 8'h5A, 0);
    ins(3, 3, 8'h05, 8'hF0, 8'h00, 0);
    ins(6, 4, 8'h07, 8'h00, 8'h00, 8'h06);
    go(30);
    chk("R2 load immediate", mem[8'hF0], 8'h5A);
    chk("R12 write cycle 5+7", first_cyc, 11);
  endtask

  task automatic t_add_wrap();
    prep();
    ins(0, 3, 8'h01, 8'h00, 8'hF0, 0);
    ins(3, 3, 8'h01, 8'h01, 8'h25, 0);
    ins(6, 3, 8'h03, 8'h00, 8'h01, 0);
    ins(9, 3, 8'h05, 8'hF0, 8'h00, 0);
    ins(12, 4, 8'h07, 8'h00, 8'h00, 8'h0C);
    go(40);
    chk("R3 add wraps mod 256", mem[8'hF0], 8'h15);
  endtask

  task automatic t_mem_add();
    prep();
    put(8'hE0, 8'h11); put(8'hE1, 8'h22);
    ins(0, 3, 8'h01, 8'h00, 8'h03, 0);
    ins(3, 3, 8'h04, 8'h00, 8'hE0, 0);   // A = 3 + 0x11
    ins(6, 3, 8'h06, 8'hE1, 8'hE0, 0);   // E1 = 0x22 + 0x11
    ins(9, 3, 8'h05, 8'hE0, 8'h00, 0);   // E0 = 0x11 + 0x14
    ins(12, 3, 8'h05, 8'hF0, 8'h00, 0);
    ins(15, 4, 8'h07, 8'h00, 8'h00, 8'h0F);
    go(60);
    chk("R4 reg += mem", mem[8'hF0], 8'h14);
    chk("R4 mem += mem", mem[8'hE1], 8'h33);
    chk("R4 mem += reg", mem[8'hE0], 8'h25);
    chk("R13 one write per memory add", wcount, 3);
  endtask

  task automatic t_ldm();
    prep();
    put(8'hE0, 8'h77);
    ins(0, 3, 8'h02, 8'h01, 8'hE0, 0);
    ins(3, 3, 8'h05, 8'hF0, 8'h01, 0);
    ins(6, 4, 8'h07, 8'h00, 8'h00, 8'h06);
    go(30);
    chk("R5 load from memory", mem[8'hF0], 8'h77);
    chk("R13 no write from loads", wcount, 1);
  endtask

  task automatic t_beq_rr();
    prep();
    ins(0, 3, 8'h01, 8'h00, 8'h05, 0);
    ins(3, 3, 8'h01, 8'h01, 8'h06, 0);
    ins(6, 4, 8'h07, 8'h00, 8'h01, 8'h0D);   // not taken
    ins(10, 3, 8'h01, 8'h02, 8'h10, 0);
    ins(13, 3, 8'h01, 8'h01, 8'h05, 0);
    ins(16, 4, 8'h07, 8'h00, 8'h01, 8'h17);  // taken
    ins(20, 3, 8'h01, 8'h02, 8'h20, 0);
    ins(23, 3, 8'h05, 8'hF0, 8'h02, 0);
    ins(26, 4, 8'h07, 8'h00, 8'h00, 8'h1A);
    go(80);
    chk("R6 branch not taken then taken", mem[8'hF0], 8'h10);
  endtask

  task automatic t_beq_mem();
    prep();
    put(8'hE0, 8'h07); put(8'hE1, 8'h07); put(8'hE2, 8'h08);
    ins(0, 3, 8'h01, 8'h00, 8'h07, 0);
    ins(3, 3, 8'h01, 8'h03, 8'h01, 0);
    ins(6, 4, 8'h08, 8'h00, 8'hE2, 8'h0D);   // not taken
    ins(10, 3, 8'h03, 8'h02, 8'h03, 0);
    ins(13, 4, 8'h08, 8'h00, 8'hE0, 8'h14);  // taken
    ins(17, 3, 8'h01, 8'h02, 8'h40, 0);
    ins(20, 4, 8'h09, 8'hE0, 8'hE1, 8'h1B);  // taken
    ins(24, 3, 8'h01, 8'h02, 8'h50, 0);
    ins(27, 4, 8'h09, 8'hE0, 8'hE2, 8'h22);  // not taken
    ins(31, 3, 8'h03, 8'h02, 8'h03, 0);
    ins(34, 3, 8'h05, 8'hF0, 8'h02, 0);
    ins(37, 4, 8'h07, 8'h00, 8'h00, 8'h25);
    go(120);
    chk("R7 memory compares", mem[8'hF0], 8'h02);
  endtask

  task automatic t_jump();
    prep();
    put(8'hE0, 8'h30);
    ins(0, 3, 8'h01, 8'h05, 8'h20, 0);
    ins(3, 2, 8'h0A, 8'h05, 0, 0);
    ins(5, 3, 8'h01, 8'h02, 8'h99, 0);
    ins(8'h20, 2, 8'h0B, 8'hE0, 0, 0);
    ins(8'h22, 3, 8'h01, 8'h02, 8'h98, 0);
    ins(8'h30, 3, 8'h01, 8'h02, 8'h42, 0);
    ins(8'h33, 3, 8'h05, 8'hF0, 8'h02, 0);
    ins(8'h36, 4, 8'h07, 8'h00, 8'h00, 8'h36);
    go(60);
    chk("R8 jump via register then memory", mem[8'hF0], 8'h42);
  endtask

  task automatic t_noop();
    prep();
    put(0, 8'h00); put(1, 8'hC7); put(2, 8'hFF);
    ins(3, 3, 8'h01, 8'h00, 8'h33, 0);
    ins(6, 3, 8'h05, 8'hF0, 8'h00, 0);
    ins(9, 4, 8'h07, 8'h00, 8'h00, 8'h09);
    go(40);
    chk("R9 no-ops skipped", mem[8'hF0], 8'h33);
    chk("R9 two cycles per no-op", first_cyc, 17);
  endtask

  task automatic t_bad_sel();
    prep();
    ins(0, 3, 8'h01, 8'h09, 8'h55, 0);       // write to unused selector
    ins(3, 3, 8'h01, 8'h00, 8'h12, 0);
    ins(6, 3, 8'h03, 8'h00, 8'h06, 0);       // A += (unused) -> +0
    ins(9, 3, 8'h05, 8'hF0, 8'h00, 0);
    ins(12, 3, 8'h05, 8'hF1, 8'h01, 0);
    ins(15, 4, 8'h07, 8'h00, 8'h00, 8'h0F);
    go(60);
    chk("R10 unused selector reads zero", mem[8'hF0], 8'h12);
    chk("R10 unused selector write discarded", mem[8'hF1], 8'h00);
  endtask

  task automatic t_wrap();
    prep();
    ins(0, 3, 8'h01, 8'h05, 8'hFB, 0);
    ins(3, 2, 8'h0A, 8'h05, 0, 0);
    ins(8'hFB, 3, 8'h01, 8'h01, 8'h66, 0);
    put(8'hFE, 8'h05); put(8'hFF, 8'hF0);   // operand 2 comes from address 0x00
    go(25);
    chk("R11 straddling write address", first_addr, 8'hF0);
    chk("R11 straddling write data", first_data, 8'h66);
    chk("R11 write cycle", first_cyc, 20);
  endtask

  task automatic t_loop();
    prep();
    ins(0, 3, 8'h01, 8'h00, 8'h00, 0);
    ins(3, 3, 8'h01, 8'h01, 8'h00, 0);
    ins(6, 3, 8'h01, 8'h02, 8'h00, 0);
    ins(9, 3, 8'h01, 8'h03, 8'h01, 0);
    ins(12, 3, 8'h01, 8'h04, 8'h03, 0);
    ins(15, 3, 8'h01, 8'h05, 8'h12, 0);
    ins(18, 3, 8'h03, 8'h00, 8'h03, 0);
    ins(21, 3, 8'h03, 8'h02, 8'h03, 0);
    ins(24, 4, 8'h07, 8'h00, 8'h04, 8'h1E);
    ins(28, 2, 8'h0A, 8'h05, 0, 0);
    ins(30, 3, 8'h01, 8'h00, 8'h00, 0);
    ins(33, 3, 8'h03, 8'h01, 8'h03, 0);
    ins(36, 4, 8'h07, 8'h01, 8'h04, 8'h2A);
    ins(40, 2, 8'h0A, 8'h05, 0, 0);
    ins(42, 3, 8'h05, 8'hF0, 8'h01, 0);
    ins(45, 3, 8'h05, 8'hF1, 8'h02, 0);
    ins(48, 4, 8'h07, 8'h00, 8'h00, 8'h30);
    go(290);
    chk("R12 loop first write cycle", first_cyc, 260);
    chk("R12 outer count", mem[8'hF0], 8'h03);
    chk("R12 total count", mem[8'hF1], 8'h09);
    chk("R13 loop write count", wcount, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ldi();
    t_add_wrap();
    t_mem_add();
    t_ldm();
    t_beq_rr();
    t_beq_mem();
    t_jump();
    t_noop();
    t_bad_sel();
    t_wrap();
    t_loop();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule